// File: doc/BRIEF.md
# Receive Descriptor and Status Ring Manager

This block sits between a MAC receive path and system memory. It manages two circular queues. Software fills one queue with free buffer descriptors. The block fills the other queue with completion records. When the MAC reports the end of a frame, the block takes the next free descriptor from memory and reads the buffer index and buffer length from it. It then writes a two-word completion record into the status queue and raises a receive interrupt. Descriptor fetches go through a simple read port that has one cycle of latency. Record writes go through a simple write port.

Software gives entries back by writing a count into one of two enqueue registers. Each count adds credit to its queue. A frame that arrives while no descriptor credit is left is dropped, and the block flags an overrun. A frame that finds no status credit waits, holding off the MAC, until software adds credit. The current address of each queue steps by 8 bytes and wraps to the base address.

Top module: `rxq_ring_mgr`

## Requirements
- R1: After reset, all base, length and current-address registers and both credit counts read 0. The maximum-length register reads 0x07FC07FC. Interrupt status and enable read 0, `rxIrq` is low and `frameReady` is high.
- R2: A frame accepted with non-zero descriptor credit issues one read of the descriptor's second word, at the descriptor current address + 4. The block takes the buffer index from bits 30:16 and the buffer length from bits 15:0. This consumes one descriptor credit and advances the descriptor current address by 8.
- R3: Status word 0 is built as follows. Bit 31 is 1. Bit 29 is 1. Bit 28 is 1 only when the frame length does not exceed the buffer length. Bits 20..16 are the error inputs `frameErr[4:0]` (4 overrun, 3 framing, 2 runt, 1 extra data, 0 CRC). Bit 1 of these (extra data) is also forced to 1 when the frame length exceeds the low 16 bits of the maximum-length register. Bit 15 is `frameCrcIncl`. Bit 30 is 1 only when bits 20..16 are all 0. All other bits are 0.
- R4: Word 0 is written at the status current address. Word 1 is written in the next cycle, at that address + 4. Word 1 holds bit 31 = 1, the buffer index in bits 30:16 and the frame length in bits 15:0.
- R5: A current address equal to base + length − 8 advances to the base address. Any other current address advances by 8.
- R6: Writing N to the descriptor enqueue register (0x0C) or the status enqueue register (0x1C) adds N to that queue's credit. Reading either register returns the credit count.
- R7: No status word is written while status credit is 0. During that wait `frameReady` stays low and interrupt status bit 0 is set. Writing word 1 consumes one status credit.
- R8: A frame offered while descriptor credit is 0 causes no memory access and leaves the descriptor pointer and credit unchanged. It sets interrupt status bit 1.
- R9: Interrupt status bit 2 is set when a record has been posted. A read at 0x24 returns the status bits and keeps them. A read at 0x28 returns them and clears them.
- R10: `rxIrq` is high exactly when any interrupt status bit 2..0 is set together with the matching bit of the enable register (0x20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read at 0x28 clears interrupt status) |
| regAddr | input | 6 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid in the same cycle |
| frameValid | input | 1 | MAC reports end of frame |
| frameReady | output | 1 | Block can take a frame end |
| frameLen | input | 16 | Received frame length in bytes |
| frameErr | input | 5 | Error flags: overrun, framing, runt, extra data, CRC |
| frameCrcIncl | input | 1 | CRC counted in the length |
| memRdEn | output | 1 | Descriptor read request |
| memRdAddr | output | 32 | Descriptor read byte address |
| memRdData | input | 32 | Read data, one cycle after the request |
| memWrEn | output | 1 | Status write strobe |
| memWrAddr | output | 32 | Status write byte address |
| memWrData | output | 32 | Status write data |
| rxIrq | output | 1 | Receive interrupt |

## Verification
Frames are sent with a clean length, with overrun and CRC flags set, with a length over the maximum that still fits the buffer, and with a length that exceeds both. Together these separate the no-error, extra-data and end-of-buffer bits of word 0. A frame offered with no descriptor credit shows that a drop is distinct from a stall. A frame offered with descriptor credit but no status credit shows the stall without the drop. A fifth frame after four takes both rings around their wrap point, so the record address and echoed index show whether the pointers return to the base. A second-word value of bits 30:16 that differs per slot shows that the index was taken from the right descriptor.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int IDX_W = 15;
  localparam int LEN_W = 16;
  localparam int WORD_W = 32;

  localparam int SEL_DBASE  = 0;
  localparam int SEL_DLEN   = 1;
  localparam int SEL_DCUR   = 2;
  localparam int SEL_DADD   = 3;
  localparam int SEL_SBASE  = 4;
  localparam int SEL_SLEN   = 5;
  localparam int SEL_SCUR   = 6;
  localparam int SEL_SADD   = 7;
  localparam int SEL_IEN    = 8;
  localparam int SEL_IPEEK  = 9;
  localparam int SEL_ITAKE  = 10;
  localparam int SEL_MAXLEN = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CAPTURE,
    ST_POST0,
    ST_POST1
  } rxq_state_t;

  typedef struct packed {
    logic accept;
    logic dropFrame;
    logic rdDesc;
    logic capDesc;
    logic stallSts;
    logic wrSts0;
    logic wrSts1;
  } rxq_strobe_t;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameValid,
  input  logic        descEmpty,
  input  logic        stsEmpty,
  output logic        frameReady,
  output rxq_strobe_t strobe
);

  rxq_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    frameReady = 1'b0;
    unique case (state)
      ST_IDLE: begin
        frameReady = 1'b1;
        if (frameValid) begin
          if (descEmpty) begin
            strobe.dropFrame = 1'b1;
          end else begin
            strobe.accept = 1'b1;
            stateNext     = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        strobe.rdDesc = 1'b1;
        stateNext     = ST_CAPTURE;
      end
      ST_CAPTURE: begin
        strobe.capDesc = 1'b1;
        stateNext      = ST_POST0;
      end
      ST_POST0: begin
        if (stsEmpty) begin
          strobe.stallSts = 1'b1;
        end else begin
          strobe.wrSts0 = 1'b1;
          stateNext     = ST_POST1;
        end
      end
      ST_POST1: begin
        strobe.wrSts1 = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rstN) // R2
    frameValid && frameReady && !descEmpty |=> !frameReady);

  AST_DROP_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN) // R8
    frameValid && frameReady && descEmpty |=> frameReady);

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) // R4
    $onehot0({strobe.rdDesc, strobe.capDesc, strobe.wrSts0, strobe.wrSts1}));

endmodule

// File: rtl/rxq_dpath.sv
module rxq_dpath
  import rxq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CREDIT_W = 16,
  parameter int REG_AW   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [4:0]        frameErr,
  input  logic              frameCrcIncl,
  input  rxq_strobe_t       strobe,
  output logic              descEmpty,
  output logic              stsEmpty,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [WORD_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic              rxIrq
);

  localparam int SEL_W = REG_AW - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] WORD1_OFS = ADDR_W'(4);
  localparam logic [WORD_W-1:0] MAXLEN_RST = {16'd2044, 16'd2044};

  logic [SEL_W-1:0] regSel;
  assign regSel = regAddr[REG_AW-1:2];

  logic [ADDR_W-1:0]   descBase, descLen, descCur;
  logic [ADDR_W-1:0]   stsBase, stsLen, stsCur;
  logic [CREDIT_W-1:0] descCredit, stsCredit;
  logic [2:0]          intStat, intEn;
  logic [WORD_W-1:0]   maxLen;

  logic [LEN_W-1:0] fLen;
  logic [4:0]       fErr;
  logic             fCrc;
  logic [IDX_W-1:0] bufIdx;
  logic [LEN_W-1:0] bufLen;

  function automatic logic [ADDR_W-1:0] ringAdvance(
    input logic [ADDR_W-1:0] cur,
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] len
  );
    if (cur == base + len - STEP) return base;
    return cur + STEP;
  endfunction

  logic wrDBase, wrDLen, wrDCur, wrDAdd, wrSBase, wrSLen, wrSCur, wrSAdd, wrIEn, wrMax;
  logic takeRd;
  always_comb begin
    wrDBase = regWrEn && (regSel == SEL_W'(SEL_DBASE));
    wrDLen  = regWrEn && (regSel == SEL_W'(SEL_DLEN));
    wrDCur  = regWrEn && (regSel == SEL_W'(SEL_DCUR));
    wrDAdd  = regWrEn && (regSel == SEL_W'(SEL_DADD));
    wrSBase = regWrEn && (regSel == SEL_W'(SEL_SBASE));
    wrSLen  = regWrEn && (regSel == SEL_W'(SEL_SLEN));
    wrSCur  = regWrEn && (regSel == SEL_W'(SEL_SCUR));
    wrSAdd  = regWrEn && (regSel == SEL_W'(SEL_SADD));
    wrIEn   = regWrEn && (regSel == SEL_W'(SEL_IEN));
    wrMax   = regWrEn && (regSel == SEL_W'(SEL_MAXLEN));
    takeRd  = regRdEn && (regSel == SEL_W'(SEL_ITAKE));
  end

  logic [CREDIT_W-1:0] descAdd, stsAdd;
  assign descAdd = wrDAdd ? regWrData[CREDIT_W-1:0] : '0;
  assign stsAdd  = wrSAdd ? regWrData[CREDIT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descBase   <= '0;
      descLen    <= '0;
      descCur    <= '0;
      stsBase    <= '0;
      stsLen     <= '0;
      stsCur     <= '0;
      descCredit <= '0;
      stsCredit  <= '0;
      intStat    <= '0;
      intEn      <= '0;
      maxLen     <= MAXLEN_RST;
      fLen       <= '0;
      fErr       <= '0;
      fCrc       <= 1'b0;
      bufIdx     <= '0;
      bufLen     <= '0;
    end else begin
      if (wrDBase) descBase <= regWrData[ADDR_W-1:0];
      if (wrDLen)  descLen  <= regWrData[ADDR_W-1:0];
      if (wrSBase) stsBase  <= regWrData[ADDR_W-1:0];
      if (wrSLen)  stsLen   <= regWrData[ADDR_W-1:0];
      if (wrIEn)   intEn    <= regWrData[2:0];
      if (wrMax)   maxLen   <= regWrData;

      if (wrDCur)              descCur <= regWrData[ADDR_W-1:0];
      else if (strobe.capDesc) descCur <= ringAdvance(descCur, descBase, descLen);

      if (wrSCur)             stsCur <= regWrData[ADDR_W-1:0];
      else if (strobe.wrSts1) stsCur <= ringAdvance(stsCur, stsBase, stsLen);

      descCredit <= descCredit + descAdd - CREDIT_W'(strobe.capDesc);
      stsCredit  <= stsCredit + stsAdd - CREDIT_W'(strobe.wrSts1);

      intStat <= (takeRd ? 3'b000 : intStat)
               | {strobe.wrSts1, strobe.dropFrame, strobe.stallSts};

      if (strobe.accept) begin
        fLen <= frameLen;
        fErr <= frameErr;
        fCrc <= frameCrcIncl;
      end
      if (strobe.capDesc) begin
        bufIdx <= memRdData[16 +: IDX_W];
        bufLen <= memRdData[LEN_W-1:0];
      end
    end
  end

  // Status record composition
  logic             oversize, fitsBuf;
  logic [4:0]       errAll;
  logic [WORD_W-1:0] word0, word1;
  always_comb begin
    oversize = fLen > maxLen[LEN_W-1:0];
    fitsBuf  = fLen <= bufLen;
    errAll   = fErr | {3'b000, oversize, 1'b0};
    word0    = {1'b1, ~|errAll, 1'b1, fitsBuf, 7'd0, errAll, fCrc, 15'd0};
    word1    = {1'b1, bufIdx, fLen};
  end

  assign descEmpty = (descCredit == '0);
  assign stsEmpty  = (stsCredit == '0);

  assign memRdEn   = strobe.rdDesc;
  assign memRdAddr = descCur + WORD1_OFS;
  assign memWrEn   = strobe.wrSts0 | strobe.wrSts1;
  assign memWrAddr = strobe.wrSts1 ? stsCur + WORD1_OFS : stsCur;
  assign memWrData = strobe.wrSts1 ? word1 : word0;

  assign rxIrq = |(intStat & intEn);

  always_comb begin
    regRdData = '0;
    case (regSel)
      SEL_W'(SEL_DBASE):  regRdData = WORD_W'(descBase);
      SEL_W'(SEL_DLEN):   regRdData = WORD_W'(descLen);
      SEL_W'(SEL_DCUR):   regRdData = WORD_W'(descCur);
      SEL_W'(SEL_DADD):   regRdData = WORD_W'(descCredit);
      SEL_W'(SEL_SBASE):  regRdData = WORD_W'(stsBase);
      SEL_W'(SEL_SLEN):   regRdData = WORD_W'(stsLen);
      SEL_W'(SEL_SCUR):   regRdData = WORD_W'(stsCur);
      SEL_W'(SEL_SADD):   regRdData = WORD_W'(stsCredit);
      SEL_W'(SEL_IEN):    regRdData = WORD_W'(intEn);
      SEL_W'(SEL_IPEEK):  regRdData = WORD_W'(intStat);
      SEL_W'(SEL_ITAKE):  regRdData = WORD_W'(intStat);
      SEL_W'(SEL_MAXLEN): regRdData = maxLen;
      default:            regRdData = '0;
    endcase
  end

  AST_WR_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rstN) // R7
    memWrEn |-> !stsEmpty);

  AST_DROP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rstN) // R8
    strobe.dropFrame && !regWrEn |=> $stable(descCur) && $stable(descCredit));

  AST_CREDIT_DEC: assert property (@(posedge clk) disable iff (!rstN) // R2
    strobe.capDesc && !regWrEn |=> descCredit == $past(descCredit) - CREDIT_W'(1));

  AST_POST_SETS_INT: assert property (@(posedge clk) disable iff (!rstN) // R9
    strobe.wrSts1 |=> intStat[2]);

  AST_WORD1_ADDR: assert property (@(posedge clk) disable iff (!rstN) // R4
    strobe.wrSts0 |=> memWrEn && memWrAddr == $past(memWrAddr) + WORD1_OFS);

endmodule

// File: rtl/rxq_ring_mgr.sv
module rxq_ring_mgr
  import rxq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CREDIT_W = 16,
  parameter int REG_AW   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              frameValid,
  output logic              frameReady,
  input  logic [15:0]       frameLen,
  input  logic [4:0]        frameErr,
  input  logic              frameCrcIncl,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [31:0]       memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic              rxIrq
);

  rxq_strobe_t strobe;
  logic        descEmpty, stsEmpty;

  rxq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameValid (frameValid),
    .descEmpty  (descEmpty),
    .stsEmpty   (stsEmpty),
    .frameReady (frameReady),
    .strobe     (strobe)
  );

  rxq_dpath #(
    .ADDR_W   (ADDR_W),
    .CREDIT_W (CREDIT_W),
    .REG_AW   (REG_AW)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regRdEn      (regRdEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .frameLen     (frameLen),
    .frameErr     (frameErr),
    .frameCrcIncl (frameCrcIncl),
    .strobe       (strobe),
    .descEmpty    (descEmpty),
    .stsEmpty     (stsEmpty),
    .memRdEn      (memRdEn),
    .memRdAddr    (memRdAddr),
    .memRdData    (memRdData),
    .memWrEn      (memWrEn),
    .memWrAddr    (memWrAddr),
    .memWrData    (memWrData),
    .rxIrq        (rxIrq)
  );

endmodule

// File: tb/rxq_ring_mgr_tb.sv
module rxq_ring_mgr_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        frameValid = 1'b0, frameReady;
  logic [15:0] frameLen = '0;
  logic [4:0]  frameErr = '0;
  logic        frameCrcIncl = 1'b0;
  logic        memRdEn, memWrEn, rxIrq;
  logic [31:0] memRdAddr, memWrAddr, memWrData;
  logic [31:0] memRdData = '0;

  always #4 clk = ~clk;

  rxq_ring_mgr u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .frameValid(frameValid), .frameReady(frameReady), .frameLen(frameLen),
    .frameErr(frameErr), .frameCrcIncl(frameCrcIncl),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .rxIrq(rxIrq)
  );

  localparam logic [31:0] D_BASE = 32'h100;
  localparam logic [31:0] S_BASE = 32'h200;
  localparam logic [31:0] RING_BYTES = 32'd32;

  logic [31:0] mem [0:255];
  always @(posedge clk) if (memRdEn) memRdData <= mem[memRdAddr[9:2]];

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  logic [63:0] expQ[$];
  string tagQ[$];
  int tbDescSlot = 0;
  logic [31:0] tbStsCur = S_BASE;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares every status write with the scoreboard head
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R7/R8 unexpected write actual=%h@%h expected=none", memWrData, memWrAddr);
      end else begin
        logic [63:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if ({memWrAddr, memWrData} !== e) begin
          nFail++;
          $display("FAIL %s actual=%h@%h expected=%h@%h", t, memWrData, memWrAddr, e[31:0], e[63:32]);
        end
      end
    end
  end

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  function automatic logic [31:0] expWord0(input logic [15:0] len, input logic [4:0] err,
                                           input logic crc, input logic [15:0] blen);
    logic [4:0] e;
    e = err | ((len > 16'd2044) ? 5'b00010 : 5'b00000);
    return {1'b1, (e == 5'b0), 1'b1, (len <= blen), 7'd0, e, crc, 15'd0};
  endfunction

  // Driver: predicts the record, then hands the frame end to the design
  task automatic offerFrame(input logic [15:0] len, input logic [4:0] err, input logic crc,
                            input bit expectPost);
    if (expectPost) begin
      logic [14:0] idx;
      idx = 15'(10 + tbDescSlot);
      expQ.push_back({tbStsCur, expWord0(len, err, crc, 16'd2048)});
      tagQ.push_back("R3 word0");
      expQ.push_back({tbStsCur + 32'd4, {1'b1, idx, len}});
      tagQ.push_back("R4 word1");
      tbDescSlot = (tbDescSlot + 1) % 4;
      tbStsCur = (tbStsCur == S_BASE + RING_BYTES - 32'd8) ? S_BASE : tbStsCur + 32'd8;
    end
    @(negedge clk);
    while (!frameReady) @(negedge clk);
    frameValid = 1'b1; frameLen = len; frameErr = err; frameCrcIncl = crc;
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 4; i++) mem[(D_BASE[9:0] + 10'(8 * i) + 10'd4) >> 2] = ((10 + i) << 16) | 2048;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(6'h2C, rd); chk("R1 max length reset", rd, 32'h07FC07FC);
    regRead(6'h08, rd); chk("R1 desc current reset", rd, 32'h0);
    regRead(6'h0C, rd); chk("R1 desc credit reset", rd, 32'h0);
    regRead(6'h24, rd); chk("R1 int status reset", rd, 32'h0);
    chk("R1 irq low", {31'd0, rxIrq}, 32'h0);
    chk("R1 frameReady high", {31'd0, frameReady}, 32'h1);

    regWrite(6'h00, D_BASE); regWrite(6'h08, D_BASE); regWrite(6'h04, RING_BYTES);
    regWrite(6'h10, S_BASE); regWrite(6'h18, S_BASE); regWrite(6'h14, RING_BYTES);

    // R8 drop with no descriptor credit
    offerFrame(16'd100, 5'b0, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    regRead(6'h24, rd); chk("R8 overrun flag", rd, 32'h2);
    regRead(6'h08, rd); chk("R8 desc pointer unchanged", rd, D_BASE);
    regRead(6'h24, rd); chk("R9 peek keeps status", rd, 32'h2);

    // R6 enqueue
    regWrite(6'h0C, 32'd4);
    regRead(6'h0C, rd); chk("R6 desc credit after enqueue", rd, 32'd4);

    // R7 stall on zero status credit
    offerFrame(16'd64, 5'b0, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk("R7 no write while stalled", 32'(expQ.size()), 32'd2);
    chk("R7 frameReady low while stalled", {31'd0, frameReady}, 32'h0);
    regRead(6'h24, rd); chk("R7 stall flag", rd & 32'h1, 32'h1);
    regWrite(6'h1C, 32'd8);
    waitDrain();
    regRead(6'h08, rd); chk("R2 desc pointer +8", rd, D_BASE + 32'd8);
    regRead(6'h0C, rd); chk("R2 desc credit consumed", rd, 32'd3);

    // R3 error flags, oversize, buffer overflow
    offerFrame(16'd1500, 5'b10001, 1'b0, 1'b1);
    waitDrain();
    offerFrame(16'd2046, 5'b0, 1'b1, 1'b1);
    waitDrain();
    offerFrame(16'd2100, 5'b00100, 1'b0, 1'b1);
    waitDrain();

    // R5 wrap
    regRead(6'h08, rd); chk("R5 desc pointer wrapped", rd, D_BASE);
    regRead(6'h18, rd); chk("R5 status pointer wrapped", rd, S_BASE);
    regRead(6'h0C, rd); chk("R6 desc credit exhausted", rd, 32'd0);
    regWrite(6'h0C, 32'd1);
    offerFrame(16'd60, 5'b0, 1'b1, 1'b1);
    waitDrain();
    regRead(6'h18, rd); chk("R5 status pointer after wrap", rd, S_BASE + 32'd8);
    regRead(6'h1C, rd); chk("R7 status credit consumed", rd, 32'd3);

    // R10 and R9
    chk("R10 irq masked", {31'd0, rxIrq}, 32'h0);
    regWrite(6'h20, 32'h4);
    chk("R10 irq raised", {31'd0, rxIrq}, 32'h1);
    regRead(6'h24, rd); chk("R9 peek all flags", rd, 32'h7);
    regRead(6'h28, rd); chk("R9 take returns flags", rd, 32'h7);
    regRead(6'h24, rd); chk("R9 take cleared", rd, 32'h0);
    chk("R10 irq dropped", {31'd0, rxIrq}, 32'h0);
    chk("R3/R4 scoreboard empty", 32'(expQ.size()), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule